// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector with Spike Filter

This block is the clocked front end of a two-wire serial slave. A fast system clock oversamples the raw clock line (SCL) and the raw data line (SDA). Each line passes through a two-flop synchronizer and then a spike filter. The filter ignores any excursion that does not last longer than a programmable number of clock cycles. From the two filtered lines the block produces single-cycle events for the protocol engine: bus start, bus stop, clock rising edge (the data sampling point) and clock falling edge (the data shifting point). It also keeps a bus-idle flag.

When the slave transmits, the protocol engine presents the level it wants on SDA. The block passes that level to the open-drain driver only after the filtered clock has been low for a programmable hold time. This keeps a transmitting slave from moving SDA close to the clock's falling edge, where another device could read the change as a start or stop. Both counts are set in system clock cycles. At 250 MHz, a spike count of 12 rejects pulses of up to 48 ns, and a hold count of 75 gives 300 ns.

Top module: `twi_cond_detect`

## Requirements
- R1: After reset, both filtered lines read 1, all four event outputs read 0, `bus_idle` reads 1 and `sda_pull_low` reads 0 (SDA released).
- R2: Each raw line is sampled by two flops. A filtered line takes a new level only when the synchronized value has differed from it at SPIKE_CNT+1 consecutive clock edges. The filtered output therefore follows a held raw change SPIKE_CNT+3 edges after the raw change. A raw pulse lasting SPIKE_CNT cycles or fewer has no effect.
- R3: `start_evt` is high for exactly one cycle, the cycle after filtered SDA falls, when filtered SCL was high both before and after that edge. A repeated start with no stop in between is reported the same way.
- R4: `stop_evt` is high for exactly one cycle, the cycle after filtered SDA rises, when filtered SCL was high both before and after that edge.
- R5: `rise_evt` is high for one cycle after each rise of filtered SCL, and `fall_evt` is high for one cycle after each fall. SDA changes while SCL is low produce no start or stop.
- R6: At most one of the four event outputs is high in any cycle.
- R7: `bus_idle` goes high in the cycle after `stop_evt`. It stays high while both filtered lines remain high. It clears on the clock edge after either filtered line is seen low, and does not come back without another stop.
- R8: `sda_pull_low` (1 = drive SDA low) takes the value of `tx_pull_low` only at a clock edge where filtered SCL has been low at HOLD_CNT+1 consecutive edges. From then until SCL rises, it follows `tx_pull_low` one edge later.
- R9: Changes of `tx_pull_low` while filtered SCL is high, or within the hold window after it falls, do not reach `sda_pull_low`, unless the value is still present once the window has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line |
| tx_pull_low | input | 1 | Level requested by the protocol engine: 1 pulls SDA low |
| scl_filt | output | 1 | Synchronized, spike-filtered SCL |
| sda_filt | output | 1 | Synchronized, spike-filtered SDA |
| start_evt | output | 1 | One-cycle start condition pulse |
| stop_evt | output | 1 | One-cycle stop condition pulse |
| rise_evt | output | 1 | One-cycle filtered SCL rising-edge pulse |
| fall_evt | output | 1 | One-cycle filtered SCL falling-edge pulse |
| bus_idle | output | 1 | Bus free: set by a stop, held while both lines are high |
| sda_pull_low | output | 1 | Delayed SDA drive request to the open-drain pad |

## Verification
The bench builds the block with SPIKE_CNT = 3 and HOLD_CNT = 5. With these values every spike width from one cycle up to the rejection limit can be driven on each line. The first width that passes, SPIKE_CNT+1, is also tried. The short hold lets the bench probe `sda_pull_low` in the last blocked cycle and in the first allowed cycle of the window. It can also withdraw a request inside the window and show that it never reaches the pad. A behavioural model follows a full frame with a start, eight data bits, a clock spike, a slave-transmit phase, a repeated start and a stop, and compares every output on every cycle.

// File: rtl/twi_cond_pkg.sv
package twi_cond_pkg;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    localparam int NUM_LINES = 2;
    localparam int LINE_SCL  = 1;
    localparam int LINE_SDA  = 0;

endpackage

// File: rtl/twi_sync2.sv
module twi_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/twi_spike_filter.sv
module twi_spike_filter #(
    parameter int   SPIKE_CNT = 12,
    parameter logic RST_LVL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = (SPIKE_CNT < 1) ? 1 : $clog2(SPIKE_CNT + 1);
    localparam logic [CNT_W-1:0] RUN_LIMIT = CNT_W'(SPIKE_CNT);

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] run;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din != st_q.lvl) begin
            if (st_q.run == RUN_LIMIT) begin
                st_d.lvl = din;
                st_d.run = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lvl: RST_LVL, run: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.lvl;
endmodule

// File: rtl/twi_cond_decode.sv
module twi_cond_decode
    import twi_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  line_pair_t filt_i,
    output bus_evt_t   evt_o,
    output logic       idle_o
);
    typedef struct packed {
        line_pair_t prev;
        logic       idle;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic    scl_steady_hi;

    always_comb begin
        scl_steady_hi = st_q.prev.scl & filt_i.scl;
        evt_o.start   = scl_steady_hi &  st_q.prev.sda & ~filt_i.sda;
        evt_o.stop    = scl_steady_hi & ~st_q.prev.sda &  filt_i.sda;
        evt_o.rise    = ~st_q.prev.scl &  filt_i.scl;
        evt_o.fall    =  st_q.prev.scl & ~filt_i.scl;

        st_d.prev = filt_i;
        if (evt_o.stop) begin
            st_d.idle = 1'b1;
        end else begin
            st_d.idle = st_q.idle & filt_i.scl & filt_i.sda;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{prev: '{scl: 1'b1, sda: 1'b1}, idle: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_o = st_q.idle;
endmodule

// File: rtl/twi_sda_hold.sv
module twi_sda_hold #(
    parameter int HOLD_CNT = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_filt,
    input  logic pull_req,
    output logic pull_out
);
    localparam int HW = (HOLD_CNT < 1) ? 1 : $clog2(HOLD_CNT + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CNT);

    typedef struct packed {
        logic          drive;
        logic [HW-1:0] wait_cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (scl_filt) begin
            st_d.wait_cnt = HOLD_LOAD;
        end else if (st_q.wait_cnt != '0) begin
            st_d.wait_cnt = st_q.wait_cnt - 1'b1;
        end else begin
            st_d.drive = pull_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{drive: 1'b0, wait_cnt: HOLD_LOAD};
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_out = st_q.drive;
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
    import twi_cond_pkg::*;
#(
    parameter int SPIKE_CNT = 12,
    parameter int HOLD_CNT  = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic tx_pull_low,
    output logic scl_filt,
    output logic sda_filt,
    output logic start_evt,
    output logic stop_evt,
    output logic rise_evt,
    output logic fall_evt,
    output logic bus_idle,
    output logic sda_pull_low
);
    logic [NUM_LINES-1:0] raw_v;
    logic [NUM_LINES-1:0] sync_v;
    logic [NUM_LINES-1:0] filt_v;
    line_pair_t           filt;
    bus_evt_t             evt;

    assign raw_v[LINE_SCL] = scl_in;
    assign raw_v[LINE_SDA] = sda_in;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        twi_sync2 #(
            .RST_VAL(1'b1)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_v[i]),
            .dout (sync_v[i])
        );

        twi_spike_filter #(
            .SPIKE_CNT(SPIKE_CNT),
            .RST_LVL  (1'b1)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (sync_v[i]),
            .dout (filt_v[i])
        );
    end

    assign filt.scl = filt_v[LINE_SCL];
    assign filt.sda = filt_v[LINE_SDA];

    twi_cond_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .filt_i(filt),
        .evt_o (evt),
        .idle_o(bus_idle)
    );

    twi_sda_hold #(
        .HOLD_CNT(HOLD_CNT)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_filt(filt.scl),
        .pull_req(tx_pull_low),
        .pull_out(sda_pull_low)
    );

    assign scl_filt  = filt.scl;
    assign sda_filt  = filt.sda;
    assign start_evt = evt.start;
    assign stop_evt  = evt.stop;
    assign rise_evt  = evt.rise;
    assign fall_evt  = evt.fall;
endmodule

// File: rtl/twi_cond_detect_chk.sv
module twi_cond_detect_chk #(
    parameter int SPIKE_CNT = 12
) (
    input logic clk,
    input logic rst_n,
    input logic scl_filt,
    input logic sda_filt,
    input logic start_evt,
    input logic stop_evt,
    input logic rise_evt,
    input logic fall_evt,
    input logic bus_idle,
    input logic sda_pull_low
);
    localparam int GW = $clog2(SPIKE_CNT + 2) + 1;
    localparam logic [GW-1:0] GAP_SAT = GW'(SPIKE_CNT + 1);

    logic          prev_scl_q, prev_sda_q;
    logic [GW-1:0] gap_scl_q, gap_sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_scl_q <= 1'b1;
            prev_sda_q <= 1'b1;
            gap_scl_q  <= '0;
            gap_sda_q  <= '0;
        end else begin
            prev_scl_q <= scl_filt;
            prev_sda_q <= sda_filt;
            gap_scl_q  <= (scl_filt != prev_scl_q) ? '0 :
                          ((gap_scl_q == GAP_SAT) ? gap_scl_q : gap_scl_q + 1'b1);
            gap_sda_q  <= (sda_filt != prev_sda_q) ? '0 :
                          ((gap_sda_q == GAP_SAT) ? gap_sda_q : gap_sda_q + 1'b1);
        end
    end

    // R2: filtered lines never toggle closer than the spike window
    assert_scl_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_filt != prev_scl_q) |-> (gap_scl_q >= GW'(SPIKE_CNT)));
    assert_sda_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_filt != prev_sda_q) |-> (gap_sda_q >= GW'(SPIKE_CNT)));

    // R3: a start leaves SDA low with SCL high, then the bus is busy
    assert_start_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> (scl_filt && !sda_filt));
    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !bus_idle);

    // R4: a stop leaves both lines high
    assert_stop_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |-> (scl_filt && sda_filt));

    // R5: edge events agree with the filtered clock level
    assert_rise_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |-> scl_filt);
    assert_fall_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |-> !scl_filt);

    // R6: events are mutually exclusive
    assert_evt_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_evt, stop_evt, rise_evt, fall_evt}));

    // R7: idle is only entered through a stop
    assert_idle_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> bus_idle);
    assert_idle_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_idle) |-> $past(stop_evt));

    // R8: the pad request never moves while the clock was high
    assert_pull_when_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_low) |-> !$past(scl_filt));
endmodule

bind twi_cond_detect twi_cond_detect_chk #(.SPIKE_CNT(SPIKE_CNT)) u_chk (.*);

// File: tb/tb_twi_cond_detect.sv
`timescale 1ns/1ps
module tb_twi_cond_detect;
    localparam int SPIKE = 3;
    localparam int HOLD  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic tx_pull_low = 1'b0;
    logic scl_filt, sda_filt, start_evt, stop_evt, rise_evt, fall_evt;
    logic bus_idle, sda_pull_low;

    always #2 clk = ~clk;

    twi_cond_detect #(.SPIKE_CNT(SPIKE), .HOLD_CNT(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .tx_pull_low(tx_pull_low), .scl_filt(scl_filt), .sda_filt(sda_filt),
        .start_evt(start_evt), .stop_evt(stop_evt), .rise_evt(rise_evt),
        .fall_evt(fall_evt), .bus_idle(bus_idle), .sda_pull_low(sda_pull_low)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    bit sync_c[$], sync_d[$];
    bit m_fs = 1, m_fd = 1, m_idle = 1, m_pull = 0;
    int run_s = 0, run_d = 0, low_run = 0;
    bit e_st = 0, e_sp = 0, e_ri = 0, e_fa = 0;

    always @(posedge clk) begin : model
        bit ns, nd, old_s, old_d;
        if (!rst_n) begin
            sync_c = '{1'b1, 1'b1};
            sync_d = '{1'b1, 1'b1};
            m_fs = 1; m_fd = 1; m_idle = 1; m_pull = 0;
            run_s = 0; run_d = 0; low_run = 0;
            e_st = 0; e_sp = 0; e_ri = 0; e_fa = 0;
        end else begin
            old_s = m_fs;
            old_d = m_fd;
            ns = old_s;
            nd = old_d;
            if (sync_c[0] != old_s) begin
                run_s++;
                if (run_s > SPIKE) begin ns = sync_c[0]; run_s = 0; end
            end else run_s = 0;
            if (sync_d[0] != old_d) begin
                run_d++;
                if (run_d > SPIKE) begin nd = sync_d[0]; run_d = 0; end
            end else run_d = 0;
            m_idle = e_sp ? 1'b1 : (m_idle && old_s && old_d);
            if (!old_s) low_run++; else low_run = 0;
            if (!old_s && low_run > HOLD) m_pull = tx_pull_low;
            e_st = old_s && ns && old_d && !nd;
            e_sp = old_s && ns && !old_d && nd;
            e_ri = !old_s && ns;
            e_fa = old_s && !ns;
            void'(sync_c.pop_front());
            void'(sync_d.pop_front());
            sync_c.push_back(scl_in);
            sync_d.push_back(sda_in);
            m_fs = ns;
            m_fd = nd;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(scl_filt == m_fs, "R2 scl_filt", scl_filt, m_fs);
            chk(sda_filt == m_fd, "R2 sda_filt", sda_filt, m_fd);
            chk(start_evt == e_st, "R3 start_evt", start_evt, e_st);
            chk(stop_evt == e_sp, "R4 stop_evt", stop_evt, e_sp);
            chk(rise_evt == e_ri, "R5 rise_evt", rise_evt, e_ri);
            chk(fall_evt == e_fa, "R5 fall_evt", fall_evt, e_fa);
            chk((start_evt + stop_evt + rise_evt + fall_evt) <= 1, "R6 exclusive",
                start_evt + stop_evt + rise_evt + fall_evt, 1);
            chk(bus_idle == m_idle, "R7 bus_idle", bus_idle, m_idle);
            chk(sda_pull_low == m_pull, "R8 sda_pull_low", sda_pull_low, m_pull);
            n_start += start_evt;
            n_stop  += stop_evt;
            n_rise  += rise_evt;
            n_fall  += fall_evt;
        end
    end

    task automatic lines(input bit c, input bit d, input int n);
        scl_in = c;
        sda_in = d;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk(scl_filt && sda_filt, "R1 filtered lines high", {scl_filt, sda_filt}, 3);
        chk(!(start_evt || stop_evt || rise_evt || fall_evt), "R1 no events",
            {start_evt, stop_evt, rise_evt, fall_evt}, 0);
        chk(bus_idle == 1'b1, "R1 idle", bus_idle, 1);
        chk(sda_pull_low == 1'b0, "R1 released", sda_pull_low, 0);
        lines(1, 1, 10);

        // R2 spikes up to SPIKE cycles are rejected
        for (int len = 1; len <= SPIKE; len++) begin
            lines(1, 0, len);
            lines(1, 1, 10);
            chk(n_start == 0 && sda_filt, "R2 SDA spike rejected", n_start, 0);
        end
        for (int len = 1; len <= SPIKE; len++) begin
            lines(0, 1, len);
            lines(1, 1, 10);
            chk(n_rise + n_fall == 0, "R2 SCL spike rejected", n_rise + n_fall, 0);
        end
        chk(bus_idle == 1'b1, "R7 idle while both high", bus_idle, 1);

        // R3 start with a pulse of exactly SPIKE+1 cycles, then held
        lines(1, 0, SPIKE + 1);
        lines(1, 0, 8);
        chk(n_start == 1, "R3 start seen", n_start, 1);
        chk(bus_idle == 1'b0, "R7 idle cleared", bus_idle, 0);

        // R5 eight data bits 0xA5, SDA moves only while SCL low
        for (int i = 7; i >= 0; i--) begin
            bit b;
            b = 1'(8'hA5 >> i);
            lines(0, sda_in, 6);
            lines(0, b, 6);
            if (i == 3) begin
                lines(1, b, 8);
                lines(0, b, SPIKE);
                lines(1, b, 8);
            end else begin
                lines(1, b, 8);
            end
        end
        chk(n_rise == 8, "R5 rise count", n_rise, 8);
        chk(n_fall == 8, "R5 fall count", n_fall, 8);
        chk(n_start == 1 && n_stop == 0, "R5 data makes no condition", n_start + n_stop, 1);

        // R8 transmit: request held back for the hold window
        tx_pull_low = 1'b1;
        lines(0, 0, SPIKE + 2 + HOLD + 1);
        chk(sda_pull_low == 1'b0, "R8 held in window", sda_pull_low, 0);
        lines(0, 0, 1);
        chk(sda_pull_low == 1'b1, "R8 released after window", sda_pull_low, 1);

        // R9 request change while SCL high is ignored
        lines(1, 0, SPIKE + 3);
        tx_pull_low = 1'b0;
        lines(1, 0, 6);
        chk(sda_pull_low == 1'b1, "R9 ignored while SCL high", sda_pull_low, 1);
        // R9 request dropped inside the window never reaches the pad
        lines(0, 0, 8);
        tx_pull_low = 1'b1;
        lines(0, 0, 8);
        chk(sda_pull_low == 1'b1, "R9 window request dropped", sda_pull_low, 1);
        tx_pull_low = 1'b0;
        lines(0, 0, 2);
        chk(sda_pull_low == 1'b0, "R8 follows after window", sda_pull_low, 0);

        // R3 repeated start
        lines(0, 1, 8);
        lines(1, 1, 8);
        lines(1, 0, 8);
        chk(n_start == 2, "R3 repeated start", n_start, 2);
        chk(bus_idle == 1'b0, "R7 no idle before stop", bus_idle, 0);

        // R4 stop
        lines(0, 0, 8);
        lines(1, 0, 8);
        lines(1, 1, 8);
        chk(n_stop == 1, "R4 stop seen", n_stop, 1);
        chk(bus_idle == 1'b1, "R7 idle after stop", bus_idle, 1);

        // R7 idle lost when SCL drops, not regained without stop
        lines(0, 1, 8);
        chk(bus_idle == 1'b0, "R7 cleared by SCL low", bus_idle, 0);
        lines(1, 1, 8);
        chk(bus_idle == 1'b0, "R7 no idle without stop", bus_idle, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog R1 run incomplete actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule